// File: doc/BRIEF.md
# Dual-Rail Add-Compare-Select Stage

This block is one add-compare-select step of a hard-decision Viterbi decoder for a single pair of trellis branches, written so that every datum travels as a dual-rail code. Each bit uses a true rail and a false rail. A bit is neutral when both rails are low, holds 0 when only the false rail is high, and holds 1 when only the true rail is high. The stage has two candidates, a and b. For each candidate it adds a branch metric to a path metric through a ripple of dual-rail full adders, and the sum saturates at the all-ones value. A dual-rail magnitude comparator then decides which sum is smaller, and a dual-rail two-way selector forwards that sum. A decision bit reports which candidate won.

A four-phase handshake controls the stage. Nothing is evaluated until every input bit carries a valid code. When the inputs are complete, the result is captured into output registers. The left acknowledge is a C-element of input completeness and output completeness, so it rises only once both are complete and falls only once both have returned to neutral. When the next stage acknowledges on the right, the outputs are precharged back to neutral before the following token is taken. The design is a clocked model of this protocol, with synchronous active-high reset and registered outputs.

Top module: `dr_acs_stage`

## Requirements
- R1: Each candidate sum equals its branch metric plus its path metric. A sum that exceeds 2^MW-1 becomes 2^MW-1 and does not wrap.
- R2: The output metric equals the smaller of the two candidate sums.
- R3: If the two sums are equal, candidate a is chosen and the decision reports a.
- R4: The decision is dual-rail. The true rail high with the false rail low means candidate a was chosen, and the false rail high with the true rail low means b was chosen. No output bit ever has both rails high.
- R5: Bit encoding on every port: true rail high means 1, false rail high means 0, both low means neutral. While any input bit is neutral, the outputs stay neutral (all rails low) and the left acknowledge stays low.
- R6: Outputs become valid on the first clock edge at which the inputs are complete, the outputs are neutral, and both acknowledges are low. They then hold steady while the right acknowledge is low.
- R7: The left acknowledge rises one clock edge after the outputs become valid, provided the inputs are still complete.
- R8: When the left acknowledge and the right acknowledge are both high, the outputs return to neutral on the next clock edge.
- R9: The left acknowledge falls one clock edge after the inputs and outputs are all neutral.
- R10: While the right acknowledge is high, a complete new input token is not evaluated. The outputs stay neutral until the right acknowledge falls.
- R11: After reset, all output rails and the left acknowledge are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_a_t | input | MW | Branch metric a, true rails |
| bm_a_f | input | MW | Branch metric a, false rails |
| pm_a_t | input | MW | Path metric a, true rails |
| pm_a_f | input | MW | Path metric a, false rails |
| bm_b_t | input | MW | Branch metric b, true rails |
| bm_b_f | input | MW | Branch metric b, false rails |
| pm_b_t | input | MW | Path metric b, true rails |
| pm_b_f | input | MW | Path metric b, false rails |
| r_ack | input | 1 | Acknowledge from the next stage |
| l_ack | output | 1 | Acknowledge to the previous stage |
| min_t | output | MW | Selected metric, true rails |
| min_f | output | MW | Selected metric, false rails |
| dec_t | output | 1 | Decision, true rail (a chosen) |
| dec_f | output | 1 | Decision, false rail (b chosen) |

## Verification
Each token is driven at a falling edge. The selected metric and the decision are due after exactly one rising edge, and the left acknowledge after a second rising edge. Precharge is requested by raising the right acknowledge together with neutral inputs. The outputs must then be neutral after one edge, and the left acknowledge must be low after the edge that follows. The bench samples at the falling edge that lies exactly that many edges later. It checks the complete code, both rails of every bit, against sums computed as integers, and it also checks that the acknowledge has not moved early. The sweep covers every metric combination at a width of three bits. Partial tokens and tokens offered while the right acknowledge is held high are checked for staying neutral over several cycles.

// File: rtl/dr_acs_pkg.sv
package dr_acs_pkg;
  localparam int unsigned DEF_MW = 4;

  // completeness of a dual-rail bus: every pair holds exactly one high rail
  function automatic logic rails_full(input logic [31:0] t, input logic [31:0] f, input int unsigned w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < w) ok = ok & (t[i] ^ f[i]);
    end
    return ok;
  endfunction

  // neutrality of a dual-rail bus: no rail high
  function automatic logic rails_empty(input logic [31:0] t, input logic [31:0] f, input int unsigned w);
    logic any;
    any = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < w) any = any | t[i] | f[i];
    end
    return ~any;
  endfunction
endpackage

// File: rtl/dr_full_adder.sv
module dr_full_adder (
  input  logic x_t,
  input  logic x_f,
  input  logic y_t,
  input  logic y_f,
  input  logic ci_t,
  input  logic ci_f,
  output logic s_t,
  output logic s_f,
  output logic co_t,
  output logic co_f
);
  // one product term per input code; a term fires only when all three bits are valid
  logic [7:0] term;

  for (genvar g = 0; g < 8; g++) begin : g_term
    localparam int unsigned K = g;
    assign term[g] = ((((K / 4) % 2) == 1) ? x_t  : x_f)
                   & ((((K / 2) % 2) == 1) ? y_t  : y_f)
                   & (((K % 2) == 1)       ? ci_t : ci_f);
  end

  assign s_t  = term[1] | term[2] | term[4] | term[7];
  assign s_f  = term[0] | term[3] | term[5] | term[6];
  assign co_t = term[3] | term[5] | term[6] | term[7];
  assign co_f = term[0] | term[1] | term[2] | term[4];
endmodule

// File: rtl/dr_sat_adder.sv
module dr_sat_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] s_t,
  output logic [W-1:0] s_f
);
  logic [W:0]   cy_t;
  logic [W:0]   cy_f;
  logic [W-1:0] raw_t;
  logic [W-1:0] raw_f;

  // constant-false carry in: neutrality still follows the operand rails
  assign cy_t[0] = 1'b0;
  assign cy_f[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    dr_full_adder u_fa (
      .x_t (a_t[i]),    .x_f (a_f[i]),
      .y_t (b_t[i]),    .y_f (b_f[i]),
      .ci_t(cy_t[i]),   .ci_f(cy_f[i]),
      .s_t (raw_t[i]),  .s_f (raw_f[i]),
      .co_t(cy_t[i+1]), .co_f(cy_f[i+1])
    );
  end

  // a true carry out forces every sum bit to one; a false carry passes the raw sum
  assign s_t = raw_t | {W{cy_t[W]}};
  assign s_f = raw_f & {W{cy_f[W]}};
endmodule

// File: rtl/dr_min_compare.sv
module dr_min_compare #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic         pick_a_t,
  output logic         pick_a_f
);
  // blt: "b is strictly below a" over bits [i:0], carried from LSB upward
  logic [W-1:0] blt_t;
  logic [W-1:0] blt_f;
  logic [W-1:0] same_t;
  logic [W-1:0] a_hi;
  logic [W-1:0] b_hi;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign same_t[i] = (a_t[i] & b_t[i]) | (a_f[i] & b_f[i]);
    assign a_hi[i]   = a_t[i] & b_f[i];
    assign b_hi[i]   = a_f[i] & b_t[i];
    if (i == 0) begin : g_lsb
      assign blt_t[i] = a_hi[i];
      assign blt_f[i] = b_hi[i] | same_t[i];
    end else begin : g_up
      assign blt_t[i] = a_hi[i] | (same_t[i] & blt_t[i-1]);
      assign blt_f[i] = b_hi[i] | (same_t[i] & blt_f[i-1]);
    end
  end

  // ties fall to candidate a
  assign pick_a_t = blt_f[W-1];
  assign pick_a_f = blt_t[W-1];
endmodule

// File: rtl/dr_select.sv
module dr_select #(
  parameter int unsigned W = 4
) (
  input  logic         sel_t,
  input  logic         sel_f,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f
);
  assign y_t = ({W{sel_t}} & a_t) | ({W{sel_f}} & b_t);
  assign y_f = ({W{sel_t}} & a_f) | ({W{sel_f}} & b_f);
endmodule

// File: rtl/dr_acs_stage.sv
module dr_acs_stage
  import dr_acs_pkg::*;
#(
  parameter int unsigned MW = DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] bm_a_t,
  input  logic [MW-1:0] bm_a_f,
  input  logic [MW-1:0] pm_a_t,
  input  logic [MW-1:0] pm_a_f,
  input  logic [MW-1:0] bm_b_t,
  input  logic [MW-1:0] bm_b_f,
  input  logic [MW-1:0] pm_b_t,
  input  logic [MW-1:0] pm_b_f,
  input  logic          r_ack,
  output logic          l_ack,
  output logic [MW-1:0] min_t,
  output logic [MW-1:0] min_f,
  output logic          dec_t,
  output logic          dec_f
);
  localparam int unsigned IW = 4 * MW;

  logic [MW-1:0] sa_t, sa_f, sb_t, sb_f;
  logic [MW-1:0] ev_t, ev_f;
  logic          pk_t, pk_f;
  logic [IW-1:0] in_t, in_f;
  logic          in_full, in_empty, out_full, out_empty;
  logic          do_eval, do_prech;

  dr_sat_adder #(.W(MW)) u_add_a (
    .a_t(bm_a_t), .a_f(bm_a_f), .b_t(pm_a_t), .b_f(pm_a_f), .s_t(sa_t), .s_f(sa_f)
  );
  dr_sat_adder #(.W(MW)) u_add_b (
    .a_t(bm_b_t), .a_f(bm_b_f), .b_t(pm_b_t), .b_f(pm_b_f), .s_t(sb_t), .s_f(sb_f)
  );
  dr_min_compare #(.W(MW)) u_cmp (
    .a_t(sa_t), .a_f(sa_f), .b_t(sb_t), .b_f(sb_f), .pick_a_t(pk_t), .pick_a_f(pk_f)
  );
  dr_select #(.W(MW)) u_sel (
    .sel_t(pk_t), .sel_f(pk_f), .a_t(sa_t), .a_f(sa_f), .b_t(sb_t), .b_f(sb_f),
    .y_t(ev_t), .y_f(ev_f)
  );

  // completion detectors
  assign in_t      = {bm_a_t, pm_a_t, bm_b_t, pm_b_t};
  assign in_f      = {bm_a_f, pm_a_f, bm_b_f, pm_b_f};
  assign in_full   = rails_full(32'(in_t), 32'(in_f), IW);
  assign in_empty  = rails_empty(32'(in_t), 32'(in_f), IW);
  assign out_full  = rails_full(32'({min_t, dec_t}), 32'({min_f, dec_f}), MW + 1);
  assign out_empty = rails_empty(32'({min_t, dec_t}), 32'({min_f, dec_f}), MW + 1);

  assign do_eval  = in_full & out_empty & ~r_ack & ~l_ack;
  assign do_prech = r_ack & l_ack & out_full;

  // output registers: evaluate or precharge
  always_ff @(posedge clk) begin
    if (rst) begin
      min_t <= '0;
      min_f <= '0;
      dec_t <= 1'b0;
      dec_f <= 1'b0;
    end else if (do_eval) begin
      min_t <= ev_t;
      min_f <= ev_f;
      dec_t <= pk_t;
      dec_f <= pk_f;
    end else if (do_prech) begin
      min_t <= '0;
      min_f <= '0;
      dec_t <= 1'b0;
      dec_f <= 1'b0;
    end
  end

  // C-element joining the input and output completion detectors
  always_ff @(posedge clk) begin
    if (rst) begin
      l_ack <= 1'b0;
    end else if (in_full && out_full) begin
      l_ack <= 1'b1;
    end else if (in_empty && out_empty) begin
      l_ack <= 1'b0;
    end
  end

  assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(|(min_t & min_f)) && !(dec_t && dec_f));
  assert_eval_needs_inputs_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_full) |-> $past(in_full));
  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (out_full && !r_ack) |=> ($stable(min_t) && $stable(min_f) && $stable(dec_t)));
  assert_ack_after_outputs_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(l_ack) |-> (out_full && $past(in_full)));
  assert_ack_fall_neutral_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(l_ack) |-> (out_empty && $past(in_empty)));
  assert_no_eval_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_full) |-> !$past(r_ack));
endmodule

// File: tb/sim_dr_acs_stage.sv
module sim_dr_acs_stage;
  localparam int unsigned MW   = 3;
  localparam int          MAXV = (1 << MW) - 1;
  localparam int          WD   = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] bm_a_t = '0, bm_a_f = '0, pm_a_t = '0, pm_a_f = '0;
  logic [MW-1:0] bm_b_t = '0, bm_b_f = '0, pm_b_t = '0, pm_b_f = '0;
  logic          r_ack = 1'b0;
  logic          l_ack;
  logic [MW-1:0] min_t, min_f;
  logic          dec_t, dec_f;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  dr_acs_stage #(.MW(MW)) u0 (
    .clk(clk), .rst(rst),
    .bm_a_t(bm_a_t), .bm_a_f(bm_a_f), .pm_a_t(pm_a_t), .pm_a_f(pm_a_f),
    .bm_b_t(bm_b_t), .bm_b_f(bm_b_f), .pm_b_t(pm_b_t), .pm_b_f(pm_b_f),
    .r_ack(r_ack), .l_ack(l_ack), .min_t(min_t), .min_f(min_f),
    .dec_t(dec_t), .dec_f(dec_f)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      nfail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int outs();
    return int'({l_ack, min_t, min_f, dec_t, dec_f});
  endfunction

  function automatic int code(input int ack, input int m, input int d);
    logic [MW-1:0] mm;
    mm = MW'(m);
    return int'({ack[0], mm, ~mm, d[0], ~d[0]});
  endfunction

  task automatic drive(input int ba, input int pa, input int bb, input int pb);
    bm_a_t = MW'(ba); bm_a_f = ~MW'(ba);
    pm_a_t = MW'(pa); pm_a_f = ~MW'(pa);
    bm_b_t = MW'(bb); bm_b_f = ~MW'(bb);
    pm_b_t = MW'(pb); pm_b_f = ~MW'(pb);
  endtask

  task automatic neutral();
    bm_a_t = '0; bm_a_f = '0; pm_a_t = '0; pm_a_f = '0;
    bm_b_t = '0; bm_b_f = '0; pm_b_t = '0; pm_b_f = '0;
  endtask

  function automatic int sat(input int x, input int y);
    return (x + y > MAXV) ? MAXV : x + y;
  endfunction

  // four-phase return: precharge then acknowledge release
  task automatic release_token();
    r_ack = 1'b1;
    neutral();
    @(negedge clk);
    chk("R8 precharge", outs(), 1 << (2 * MW + 2));
    @(negedge clk);
    chk("R9 ack fall", int'(l_ack), 0);
    r_ack = 1'b0;
  endtask

  task automatic token(input int ba, input int pa, input int bb, input int pb);
    int sa, sb, m, d;
    string req;
    sa = sat(ba, pa);
    sb = sat(bb, pb);
    d  = (sa <= sb) ? 1 : 0;
    m  = d ? sa : sb;
    if (sa == sb)                           req = "R3 tie";
    else if (ba + pa > MAXV || bb + pb > MAXV) req = "R1 saturate";
    else                                    req = "R2 min";
    @(negedge clk);
    drive(ba, pa, bb, pb);
    @(negedge clk);
    chk({req, " R4 R6 result"}, outs(), code(0, m, d));
    @(negedge clk);
    chk("R7 ack rise", outs(), code(1, m, d));
    release_token();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 reset", outs(), 0);

    // partial input: only branch metric a valid
    @(negedge clk);
    bm_a_t = MW'(5); bm_a_f = ~MW'(5);
    repeat (3) @(negedge clk);
    chk("R5 partial", outs(), 0);
    // all but one false rail of pm_b
    drive(1, 2, 3, 0);
    pm_b_f[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 one bit missing", outs(), 0);
    pm_b_f[0] = 1'b1;
    @(negedge clk);
    chk("R5 completed", outs(), code(0, 3, 1));
    @(negedge clk);
    release_token();

    // new token while the right acknowledge is still high
    @(negedge clk);
    r_ack = 1'b1;
    drive(6, 4, 2, 1);
    repeat (3) @(negedge clk);
    chk("R10 blocked", outs(), 0);
    r_ack = 1'b0;
    @(negedge clk);
    chk("R10 released", outs(), code(0, 3, 0));
    @(negedge clk);
    release_token();

    // exhaustive sweep
    for (int ba = 0; ba <= MAXV; ba++)
      for (int pa = 0; pa <= MAXV; pa++)
        for (int bb = 0; bb <= MAXV; bb++)
          for (int pb = 0; pb <= MAXV; pb++)
            token(ba, pa, bb, pb);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule